// File: doc/BRIEF.md
# Reseedable Spectral Test Pattern Channel

This block is the output stage of a built-in self-test pattern generator for a combinational circuit under test. Each bit of the output vector drives one input of that circuit. Each bit is one of three things: a Walsh component chosen from an externally generated Walsh bus, that same component inverted by a weighted random noise bit, or a weighted random stream bit that replaces the component. Which one each bit gets is set by a per-bit configuration held in the block.

All configuration comes from an external tester as a seed. The seed holds one configuration field per output bit and a run length. The tester writes the seed into a staging register on its own slow clock. It can write the whole seed in one tester cycle, or shift it in one bit per tester cycle. It then commits the seed. The commit crosses to the fast system clock through a toggle handshake. The tester-side busy flag stays high until the system side has taken the seed.

Two operating modes exist. In tester mode, each seed produces exactly one vector and the block then waits for the next seed. In hybrid mode, the seed vector is followed by one newly generated vector per system clock for the programmed run length. The block then raises a reseed request. While a serial shift is under way, generation pauses and the output vector holds.

Top module: `spectral_tpg_chan`

## Requirements
- R1: While reset is applied and after it is released, with no seed committed, the outputs are: cut_vec all zero, seed_done 0, reseed_req 1, gen_step 0 and tst_busy 0.
- R2: Output bit i is decoded from its own configuration field. When rs=1, the bit equals strm[i], whatever ne is. When rs=0 and ne=0, the bit equals walsh[idx]. When rs=0 and ne=1, the bit equals walsh[idx] XOR noise[i].
- R3: Seed layout. The configuration field of bit i sits at seed bits [i*CFG_W +: CFG_W], where CFG_W = IDX_W+2, and reads {rs, ne, idx}, with idx in the low IDX_W bits. The run length occupies the top RUN_W bits of the seed. A tester cycle with tst_load=1 captures the whole of tst_word into the staging register.
- R4: Each tester cycle with tst_shift=1 shifts tst_sdi into staging bit 0 and moves the other bits up by one. The seed is therefore sent most significant bit first, and after SEED_W shifts it is complete.
- R5: In tester mode (mode=0), a commit does three things: it produces exactly one vector from the committed seed and the current inputs, it pulses seed_done, and it raises reseed_req. After that the vector does not change and gen_step stays 0 until the next commit.
- R6: In hybrid mode (mode=1), the seed vector is followed by one registered update per system clock for run-length cycles. Each update uses the inputs present at that edge, and gen_step is 1 on each cycle that produces an update.
- R7: In hybrid mode, reseed_req rises together with the last generated vector. After that, cut_vec holds until the next commit. A run length of 0 yields only the seed vector, with reseed_req already high.
- R8: A serial load is in progress from its first accepted shift until its commit. During that time cut_vec holds, the run count pauses and gen_step is 0.
- R9: seed_done is a single system-clock pulse per commit. It is high in the first cycle in which the seed vector is on cut_vec.
- R10: tst_busy goes high at the commit edge and stays high until the system side has taken the seed. While tst_busy is high, tst_load, tst_shift and tst_commit are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| tck | input | 1 | Tester clock, slower than clk |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| mode | input | 1 | 0 = tester mode (one vector per seed), 1 = hybrid mode (seed, then a run) |
| walsh | input | NUM_WALSH | Walsh component bus from the external wave generator |
| noise | input | NUM_OUT | Weighted random noise bits, one per output bit |
| strm | input | NUM_OUT | Weighted random stream bits, one per output bit |
| tst_load | input | 1 | Capture tst_word into the staging register (tck domain) |
| tst_word | input | SEED_W | Parallel seed word |
| tst_shift | input | 1 | Shift tst_sdi into the staging register (tck domain) |
| tst_sdi | input | 1 | Serial seed data, most significant bit first |
| tst_commit | input | 1 | Hand the staged seed to the system side (tck domain) |
| tst_busy | output | 1 | Commit handshake pending; tester inputs ignored |
| gen_step | output | 1 | Generation update this cycle; advance the external generators |
| seed_done | output | 1 | One-cycle pulse when the seed vector is applied |
| reseed_req | output | 1 | Run finished or no seed yet; ready for the next seed |
| cut_vec | output | NUM_OUT | Registered test vector to the circuit under test |

## Verification
The bench targets the following failure modes and what each would look like at the outputs:
- **Selection priority in R2.** A lane that lets noise leak into a random-select bit, or that picks the wrong Walsh index, shows up as a wrong vector bit under patterns that separate the three sources.
- **Off-by-one in the run counter.** This would show up as one generated vector too many or too few before reseed_req rises, or as reseed_req rising one cycle away from the last vector. A run length of zero is covered separately.
- **Freeze during a serial load.** A design that keeps generating while bits arrive would change cut_vec while the Walsh inputs move.
- **Load during a busy handshake.** A design that accepts a parallel load while busy would make the second commit apply a different seed from the one staged first.

// File: rtl/spc_pkg.sv
package spc_pkg;

  typedef enum logic {
    MODE_TESTER = 1'b0,
    MODE_HYBRID = 1'b1
  } spc_mode_e;

endpackage

// File: rtl/spc_rst_sync.sv
module spc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];

endmodule

// File: rtl/spc_bit_sync.sv
module spc_bit_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] meta_q;
  logic [W-1:0] safe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      safe_q <= '0;
    end else begin
      meta_q <= d;
      safe_q <= meta_q;
    end
  end

  assign q = safe_q;

endmodule

// File: rtl/spc_seed_port.sv
module spc_seed_port #(
  parameter int SEED_W = 52
) (
  input  logic              tck,
  input  logic              rst_n,
  input  logic              ld,
  input  logic [SEED_W-1:0] word,
  input  logic              shift,
  input  logic              sdi,
  input  logic              commit,
  input  logic              ack_sync,
  output logic [SEED_W-1:0] stage,
  output logic              req_tog,
  output logic              shifting,
  output logic              pending
);

  logic [SEED_W-1:0] stage_q, stage_d;
  logic              req_q, req_d;
  logic              shf_q, shf_d;
  logic              accept;

  assign pending = req_q ^ ack_sync;
  assign accept  = !pending;

  always_comb begin
    stage_d = stage_q;
    req_d   = req_q;
    shf_d   = shf_q;
    if (accept) begin
      if (ld) begin
        stage_d = word;
      end else if (shift) begin
        stage_d = {stage_q[SEED_W-2:0], sdi};
        shf_d   = 1'b1;
      end
      if (commit) begin
        req_d = !req_q;
        shf_d = 1'b0;
      end
    end
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      req_q   <= 1'b0;
      shf_q   <= 1'b0;
    end else begin
      stage_q <= stage_d;
      req_q   <= req_d;
      shf_q   <= shf_d;
    end
  end

  assign stage    = stage_q;
  assign req_tog  = req_q;
  assign shifting = shf_q;

endmodule

// File: rtl/spc_lane_array.sv
module spc_lane_array #(
  parameter int NUM_OUT   = 8,
  parameter int NUM_WALSH = 8,
  parameter int IDX_W     = 3
) (
  input  logic [NUM_OUT*(IDX_W+2)-1:0] cfg_bus,
  input  logic [NUM_WALSH-1:0]         walsh,
  input  logic [NUM_OUT-1:0]           noise,
  input  logic [NUM_OUT-1:0]           strm,
  output logic [NUM_OUT-1:0]           vec_d
);

  localparam int CFG_W = IDX_W + 2;

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_lane
    logic [IDX_W-1:0] idx;
    logic             ne;
    logic             rs;
    logic             comp;

    assign idx = cfg_bus[i*CFG_W +: IDX_W];
    assign ne  = cfg_bus[i*CFG_W + IDX_W];
    assign rs  = cfg_bus[i*CFG_W + IDX_W + 1];

    always_comb begin
      comp = 1'b0;
      for (int k = 0; k < NUM_WALSH; k++) begin
        if (idx == k[IDX_W-1:0]) comp = walsh[k];
      end
    end

    assign vec_d[i] = rs ? strm[i] : (comp ^ (ne & noise[i]));
  end

endmodule

// File: rtl/spc_run_ctrl.sv
module spc_run_ctrl #(
  parameter int RUN_W = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  commit_pulse,
  input  spc_pkg::spc_mode_e    mode,
  input  logic [RUN_W-1:0]      run_len,
  input  logic                  freeze,
  output logic                  upd,
  output logic                  gen_step,
  output logic                  seed_done,
  output logic                  reseed_req
);

  import spc_pkg::*;

  logic [RUN_W-1:0] cnt_q, cnt_d;
  logic             run_q, run_d;
  logic             req_q, req_d;
  logic             done_q, done_d;
  logic             step;

  assign step = run_q && !freeze;

  always_comb begin
    cnt_d  = cnt_q;
    run_d  = run_q;
    req_d  = req_q;
    done_d = 1'b0;
    if (commit_pulse) begin
      done_d = 1'b1;
      if (mode == MODE_HYBRID) begin
        cnt_d = run_len;
        run_d = (run_len != '0);
        req_d = (run_len == '0);
      end else begin
        cnt_d = '0;
        run_d = 1'b0;
        req_d = 1'b1;
      end
    end else if (step) begin
      cnt_d = cnt_q - RUN_W'(1);
      if (cnt_q == RUN_W'(1)) begin
        run_d = 1'b0;
        req_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      run_q  <= 1'b0;
      req_q  <= 1'b1;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      run_q  <= run_d;
      req_q  <= req_d;
      done_q <= done_d;
    end
  end

  assign upd        = commit_pulse || step;
  assign gen_step   = step;
  assign seed_done  = done_q;
  assign reseed_req = req_q;

endmodule

// File: rtl/spectral_tpg_chan.sv
module spectral_tpg_chan #(
  parameter int NUM_OUT   = 8,
  parameter int NUM_WALSH = 8,
  parameter int RUN_W     = 12,
  parameter int IDX_W     = (NUM_WALSH > 1) ? $clog2(NUM_WALSH) : 1,
  parameter int SEED_W    = NUM_OUT * (IDX_W + 2) + RUN_W
) (
  input  logic                 clk,
  input  logic                 tck,
  input  logic                 rst_n,
  input  logic                 mode,
  input  logic [NUM_WALSH-1:0] walsh,
  input  logic [NUM_OUT-1:0]   noise,
  input  logic [NUM_OUT-1:0]   strm,
  input  logic                 tst_load,
  input  logic [SEED_W-1:0]    tst_word,
  input  logic                 tst_shift,
  input  logic                 tst_sdi,
  input  logic                 tst_commit,
  output logic                 tst_busy,
  output logic                 gen_step,
  output logic                 seed_done,
  output logic                 reseed_req,
  output logic [NUM_OUT-1:0]   cut_vec
);

  import spc_pkg::*;

  localparam int CFG_W   = IDX_W + 2;
  localparam int CFGS_W  = NUM_OUT * CFG_W;

  logic              rst_c_n;
  logic              rst_t_n;
  logic [SEED_W-1:0] stage;
  logic              req_tog_t;
  logic              shifting_t;
  logic              ack_t;
  logic [1:0]        sync_c;
  logic              req_s3_q;
  logic              commit_pulse;
  logic              frz;
  logic              upd;
  logic [CFGS_W-1:0] cfg_q, cfg_d, cfg_sel;
  logic [NUM_OUT-1:0] vec_d;
  logic [NUM_OUT-1:0] cut_q, cut_d;

  spc_rst_sync u_rst_c (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_c_n));
  spc_rst_sync u_rst_t (.clk(tck), .rst_n(rst_n), .rst_sync_n(rst_t_n));

  spc_seed_port #(.SEED_W(SEED_W)) u_port (
    .tck      (tck),
    .rst_n    (rst_t_n),
    .ld       (tst_load),
    .word     (tst_word),
    .shift    (tst_shift),
    .sdi      (tst_sdi),
    .commit   (tst_commit),
    .ack_sync (ack_t),
    .stage    (stage),
    .req_tog  (req_tog_t),
    .shifting (shifting_t),
    .pending  (tst_busy)
  );

  spc_bit_sync #(.W(2)) u_sync_c (
    .clk   (clk),
    .rst_n (rst_c_n),
    .d     ({shifting_t, req_tog_t}),
    .q     (sync_c)
  );

  spc_bit_sync #(.W(1)) u_sync_t (
    .clk   (tck),
    .rst_n (rst_t_n),
    .d     (req_s3_q),
    .q     (ack_t)
  );

  assign commit_pulse = sync_c[0] ^ req_s3_q;
  assign frz          = sync_c[1];

  spc_run_ctrl #(.RUN_W(RUN_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_c_n),
    .commit_pulse (commit_pulse),
    .mode         (spc_mode_e'(mode)),
    .run_len      (stage[SEED_W-1 -: RUN_W]),
    .freeze       (frz),
    .upd          (upd),
    .gen_step     (gen_step),
    .seed_done    (seed_done),
    .reseed_req   (reseed_req)
  );

  assign cfg_sel = commit_pulse ? stage[CFGS_W-1:0] : cfg_q;

  spc_lane_array #(
    .NUM_OUT   (NUM_OUT),
    .NUM_WALSH (NUM_WALSH),
    .IDX_W     (IDX_W)
  ) u_lanes (
    .cfg_bus (cfg_sel),
    .walsh   (walsh),
    .noise   (noise),
    .strm    (strm),
    .vec_d   (vec_d)
  );

  always_comb begin
    cfg_d = commit_pulse ? stage[CFGS_W-1:0] : cfg_q;
    cut_d = upd ? vec_d : cut_q;
  end

  always_ff @(posedge clk or negedge rst_c_n) begin
    if (!rst_c_n) begin
      req_s3_q <= 1'b0;
      cfg_q    <= '0;
      cut_q    <= '0;
    end else begin
      req_s3_q <= sync_c[0];
      cfg_q    <= cfg_d;
      cut_q    <= cut_d;
    end
  end

  assign cut_vec = cut_q;

endmodule

// File: rtl/spectral_tpg_chan_chk.sv
module spectral_tpg_chan_chk #(
  parameter int NUM_OUT = 8
) (
  input logic               clk,
  input logic               tck,
  input logic               rst_c_n,
  input logic               rst_t_n,
  input logic               tst_commit,
  input logic               tst_busy,
  input logic               gen_step,
  input logic               seed_done,
  input logic               reseed_req,
  input logic [NUM_OUT-1:0] cut_vec
);

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_c_n)
    seed_done |=> !seed_done);

  a_r7_hold_after_req: assert property (@(posedge clk) disable iff (!rst_c_n)
    reseed_req |=> (seed_done || $stable(cut_vec)));

  a_r6_update_on_step: assert property (@(posedge clk) disable iff (!rst_c_n)
    !gen_step |=> (seed_done || $stable(cut_vec)));

  a_r7_no_step_when_req: assert property (@(posedge clk) disable iff (!rst_c_n)
    reseed_req |-> !gen_step);

  a_r10_busy_after_commit: assert property (@(posedge tck) disable iff (!rst_t_n)
    (tst_commit && !tst_busy) |=> tst_busy);

endmodule

bind spectral_tpg_chan spectral_tpg_chan_chk #(.NUM_OUT(NUM_OUT)) u_chk (
  .clk        (clk),
  .tck        (tck),
  .rst_c_n    (rst_c_n),
  .rst_t_n    (rst_t_n),
  .tst_commit (tst_commit),
  .tst_busy   (tst_busy),
  .gen_step   (gen_step),
  .seed_done  (seed_done),
  .reseed_req (reseed_req),
  .cut_vec    (cut_vec)
);

// File: tb/tb_spectral_tpg_chan.sv
`timescale 1ns/1ps
module tb_spectral_tpg_chan;

  localparam int NO     = 8;
  localparam int NW     = 8;
  localparam int RW     = 12;
  localparam int IW     = 3;
  localparam int CW     = IW + 2;
  localparam int SW     = NO * CW + RW;

  logic clk = 1'b0;
  logic tck = 1'b0;
  logic rst_n;
  logic mode;
  logic [NW-1:0] walsh;
  logic [NO-1:0] noise, strm;
  logic tst_load, tst_shift, tst_sdi, tst_commit;
  logic [SW-1:0] tst_word;
  logic tst_busy, gen_step, seed_done, reseed_req;
  logic [NO-1:0] cut_vec;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;
  initial begin
    #1;
    forever #10 tck = ~tck;
  end

  spectral_tpg_chan #(.NUM_OUT(NO), .NUM_WALSH(NW), .RUN_W(RW)) dut (
    .clk(clk), .tck(tck), .rst_n(rst_n), .mode(mode),
    .walsh(walsh), .noise(noise), .strm(strm),
    .tst_load(tst_load), .tst_word(tst_word), .tst_shift(tst_shift),
    .tst_sdi(tst_sdi), .tst_commit(tst_commit), .tst_busy(tst_busy),
    .gen_step(gen_step), .seed_done(seed_done), .reseed_req(reseed_req),
    .cut_vec(cut_vec)
  );

  // stimulus {walsh, noise, strm}
  localparam logic [23:0] STIM [0:5] = '{
    24'hA5_FF_00, 24'h3C_00_FF, 24'hFF_AA_80, 24'h00_FF_7F, 24'h69_55_01, 24'hC3_0F_F0
  };

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // kinds: 0 A, 1 B, 2 C, 3 D, 4 E
  function automatic logic [SW-1:0] mk_seed(int kind, int run);
    logic [SW-1:0] s;
    logic [IW-1:0] idx;
    logic ne, rs;
    s = '0;
    for (int i = 0; i < NO; i++) begin
      case (kind)
        0: begin idx = IW'(i); ne = (i == 1 || i == 3 || i == 5); rs = (i == 7); end
        1: begin idx = IW'((i * 3) % 8); ne = 1'b1; rs = 1'b0; end
        2: begin idx = IW'(7 - i); ne = (i == 0); rs = (i == 6); end
        3: begin idx = 3'd2; ne = 1'b0; rs = 1'b0; end
        default: begin idx = IW'(i); ne = 1'b0; rs = 1'b0; end
      endcase
      s[i*CW +: CW] = {rs, ne, idx};
    end
    s[SW-1 -: RW] = RW'(run);
    return s;
  endfunction

  function automatic logic [NO-1:0] ref_vec(logic [SW-1:0] s, logic [NW-1:0] w,
                                            logic [NO-1:0] n, logic [NO-1:0] r);
    logic [NO-1:0] v;
    logic [IW-1:0] idx;
    for (int i = 0; i < NO; i++) begin
      idx = s[i*CW +: IW];
      if (s[i*CW + IW + 1]) v[i] = r[i];
      else                  v[i] = w[idx] ^ (s[i*CW + IW] & n[i]);
    end
    return v;
  endfunction

  task automatic drive(logic [23:0] st);
    walsh = st[23:16]; noise = st[15:8]; strm = st[7:0];
  endtask

  task automatic t_load(logic [SW-1:0] s);
    @(negedge tck);
    tst_word = s; tst_load = 1'b1;
    @(negedge tck);
    tst_load = 1'b0;
  endtask

  task automatic t_commit();
    @(negedge tck);
    tst_commit = 1'b1;
    @(posedge tck);
    #1 tst_commit = 1'b0;
  endtask

  task automatic t_idle();
    for (int k = 0; k < 50; k++) begin
      @(negedge tck);
      if (!tst_busy) break;
    end
  endtask

  task automatic c_done(string tag);
    bit seen = 0;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      if (seed_done) begin seen = 1; break; end
    end
    chk(tag, 64'(seen), 64'd1);
  endtask

  task automatic finish_run();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog act=hung exp=done");
      finish_run();
    end
  end

  initial begin
    logic [SW-1:0] sA, sB, sC, sD, sE;
    logic [NO-1:0] snap;
    bit frozen_ok;
    sA = mk_seed(0, 6);
    sB = mk_seed(1, 0);
    sC = mk_seed(2, 9);
    sD = mk_seed(3, 3);
    sE = mk_seed(4, 300);
    rst_n = 1'b0; mode = 1'b1;
    tst_load = 0; tst_shift = 0; tst_sdi = 0; tst_commit = 0; tst_word = '0;
    drive(24'h00_00_00);

    // R1 reset state
    #30;
    chk("R1 cut_vec in reset", 64'(cut_vec), 64'd0);
    chk("R1 reseed_req in reset", 64'(reseed_req), 64'd1);
    chk("R1 seed_done in reset", 64'(seed_done), 64'd0);
    rst_n = 1'b1;
    repeat (12) @(negedge clk);
    chk("R1 outputs after release",
        64'({cut_vec, seed_done, reseed_req, gen_step, tst_busy}), 64'({8'h00, 4'b0100}));

    // R3 parallel load, R6/R7 hybrid run of 6 walked from the table
    drive(STIM[5]);
    t_load(sA);
    t_commit();
    c_done("R9 seed_done after parallel commit");
    chk("R2 R3 seed vector A", 64'(cut_vec), 64'(ref_vec(sA, STIM[5][23:16], STIM[5][15:8], STIM[5][7:0])));
    for (int k = 0; k < 6; k++) begin
      chk("R6 gen_step during run", 64'(gen_step), 64'd1);
      drive(STIM[k]);
      @(negedge clk);
      if (k == 0) chk("R9 seed_done single pulse", 64'(seed_done), 64'd0);
      chk("R2 R6 generated vector", 64'(cut_vec),
          64'(ref_vec(sA, STIM[k][23:16], STIM[k][15:8], STIM[k][7:0])));
      chk("R7 reseed_req timing", 64'(reseed_req), 64'(k == 5));
    end
    snap = cut_vec;
    drive(24'h5A_5A_5A);
    repeat (4) @(negedge clk);
    chk("R7 hold after run", 64'(cut_vec), 64'(snap));
    chk("R6 gen_step low after run", 64'(gen_step), 64'd0);
    t_idle();

    // R5 tester mode: one vector then hold
    mode = 1'b0;
    drive(STIM[2]);
    t_load(sC);
    t_commit();
    c_done("R5 seed_done tester mode");
    chk("R5 R2 tester vector C", 64'(cut_vec), 64'(ref_vec(sC, STIM[2][23:16], STIM[2][15:8], STIM[2][7:0])));
    chk("R5 reseed_req tester mode", 64'(reseed_req), 64'd1);
    snap = cut_vec;
    drive(STIM[3]);
    repeat (5) @(negedge clk);
    chk("R5 hold in tester mode", 64'({cut_vec, gen_step}), 64'({snap, 1'b0}));
    t_idle();

    // R10 busy and ignore; R7 run length zero
    mode = 1'b1;
    drive(STIM[4]);
    t_load(sB);
    t_commit();
    chk("R10 busy after commit", 64'(tst_busy), 64'd1);
    t_load(sA);
    t_idle();
    chk("R10 busy clears", 64'(tst_busy), 64'd0);
    drive(STIM[1]);
    t_commit();
    c_done("R10 second commit done");
    chk("R10 ignored load keeps seed B", 64'(cut_vec),
        64'(ref_vec(sB, STIM[1][23:16], STIM[1][15:8], STIM[1][7:0])));
    chk("R7 run zero reseed_req", 64'(reseed_req), 64'd1);
    snap = cut_vec;
    drive(STIM[0]);
    repeat (3) @(negedge clk);
    chk("R7 run zero holds", 64'(cut_vec), 64'(snap));
    t_idle();

    // R6 long run follows inputs, R8 freeze during serial load, R4 serial seed
    t_load(sE);
    t_commit();
    c_done("R6 long run start");
    for (int k = 0; k < 4; k++) begin
      drive(STIM[k]);
      @(negedge clk);
      chk("R6 long run follows walsh", 64'(cut_vec), 64'(STIM[k][23:16]));
    end
    t_idle();
    frozen_ok = 1;
    snap = '0;
    for (int b = SW - 1; b >= 0; b--) begin
      @(negedge tck);
      tst_shift = 1'b1; tst_sdi = sD[b];
      if (b == SW - 4) snap = cut_vec;
      if (b < SW - 4) begin
        if (cut_vec !== snap || gen_step !== 1'b0) frozen_ok = 0;
        walsh = ~walsh ^ 8'(b);
      end
    end
    @(negedge tck);
    tst_shift = 1'b0;
    chk("R8 frozen during serial load", 64'(frozen_ok), 64'd1);
    drive(STIM[3]);
    t_commit();
    c_done("R4 serial commit done");
    chk("R4 serial seed vector D", 64'(cut_vec), 64'(ref_vec(sD, STIM[3][23:16], STIM[3][15:8], STIM[3][7:0])));
    for (int k = 0; k < 3; k++) begin
      drive(STIM[k + 2]);
      @(negedge clk);
      chk("R4 R6 serial run vector", 64'(cut_vec),
          64'(ref_vec(sD, STIM[k+2][23:16], STIM[k+2][15:8], STIM[k+2][7:0])));
      chk("R7 serial run reseed_req", 64'(reseed_req), 64'(k == 2));
    end

    finish_run();
  end

endmodule